// File: doc/BRIEF.md
# Stream-to-Memory Receive DMA Engine

This block is the receive half of one DMA channel. A byte stream arrives with a valid/ready handshake and an end-of-packet marker. The engine stores the bytes into memory buffers described by linked four-word descriptors. A start pulse hands the engine the address of the first descriptor and the address of the context descriptor that owns the list. The engine then reads the descriptor and fills its buffer. Bytes are packed little-endian into 32-bit words. Partial words are written with byte enables only.

A descriptor closes when its buffer is full or when a packet ends, whichever comes first. On close, the engine rewrites the descriptor's end pointer with the real fill position, so a short packet truncates the descriptor. It also marks the received-end-of-packet flag when a packet end caused the close, and writes the flags word back. Next it raises the raw interrupt bits. It then either follows the next pointer or, at the end of the list, writes the context back with its disable bit set and stops accepting input.

Memory is a single port with a fixed read latency of one cycle and no back-pressure. Descriptor layout, as byte offsets from the descriptor address: +0 next pointer, +4 buffer start, +8 flags, +12 end pointer. The end pointer is exclusive.

Top module: `rxdma_engine`

## Requirements
- R1: After reset, `s_ready_o`, `eol_o` and `irq_o` are low and `raw_intr_o` is 0.
- R2: An accepted byte goes to the address in the fill pointer, on byte lane `addr[1:0]` of the word at `addr` with bits 1:0 cleared, little-endian. Writes carry byte enables for the accepted bytes only, so bytes outside the buffer keep their old values.
- R3: At most (end pointer − buffer start) bytes are accepted into one descriptor. When the fill pointer reaches the end pointer, the descriptor closes and `s_ready_o` stays low until the next descriptor is loaded.
- R4: A byte with `s_eop_i` high closes the descriptor after that byte is stored. On every close, the end-pointer word (+12) is overwritten with the final fill pointer.
- R5: When the close was caused by end-of-packet, bit 11 of the flags word is set in the write-back and raw interrupt bit 3 is set. All other flag bits are written back unchanged.
- R6: When flags bit 4 (interrupt request) of the closing descriptor is set, raw interrupt bits 0 and 1 are both set.
- R7: `irq_o` is high when `raw_intr_o & intr_mask_i` is non-zero and is re-evaluated when the raw value or the mask changes. A one-cycle pulse on a bit of `intr_ack_i` clears that raw bit.
- R8: When flags bit 0 (end of list) is set, the flags write-back happens first. The engine then reads the context word at context address +4 and writes it back with bit 15 set and all other bits unchanged. It raises `eol_o` and keeps `s_ready_o` low until the next start pulse.
- R9: Without end of list, the engine loads the descriptor at the next pointer (+0) and resumes filling at that descriptor's buffer start (+4). A start pulse in the idle or stopped state loads the descriptor at `desc_ptr_i`.
- R10: `saved_buf_o` shows the current fill pointer. It advances by one for each accepted byte and equals the buffer start right after a descriptor is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, honoured when idle or stopped |
| desc_ptr_i | input | AW | Byte address of the first data descriptor |
| ctx_ptr_i | input | AW | Byte address of the context descriptor |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_eop_i | input | 1 | Marks the last byte of a packet |
| s_ready_o | output | 1 | Engine takes the byte this cycle |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables of a write |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read |
| intr_mask_i | input | 4 | Interrupt mask |
| intr_ack_i | input | 4 | Per-bit clear pulse for raw interrupts |
| raw_intr_o | output | 4 | Raw interrupt bits |
| irq_o | output | 1 | Masked interrupt line |
| eol_o | output | 1 | End of list reached, input refused |
| saved_buf_o | output | AW | Current fill pointer |

## Verification
The in-line assertions watch invariants that hold on every cycle. Ready is never high in the stopped state. The fill pointer steps by exactly one per accepted byte and never passes the end pointer. Every data write carries at least one byte enable. The context write with the disable bit comes before the stop flag rises. Acknowledged raw bits clear. What the assertions cannot show is the memory image: byte placement on unaligned and partial buffers, the rewritten end pointer and flags, the preserved context bits, and the chaining to a second descriptor. The bench covers these by running scenarios against its own memory model and comparing with expected images computed from the requirements.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int LANES       = 4;
  localparam int FLAG_EOL    = 0;
  localparam int FLAG_INTR   = 4;
  localparam int FLAG_INEOP  = 11;
  localparam int CTX_DIS     = 15;
  localparam int NIRQ        = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FCAP, ST_RUN, ST_WRW,
    ST_WEND, ST_WFLG, ST_CREQ, ST_CCAP, ST_HALT
  } rx_state_e;

  // Flush the packing word after this byte?
  function automatic logic must_flush(input logic [1:0] lane,
                                      input logic full_next,
                                      input logic eop);
    return (lane == 2'd3) || full_next || eop;
  endfunction

  // Flags word as written back on close.
  function automatic logic [31:0] close_flags(input logic [31:0] flags,
                                              input logic eop_close);
    logic [31:0] f;
    f = flags;
    if (eop_close) f[FLAG_INEOP] = 1'b1;
    return f;
  endfunction

  // Raw interrupt bits raised on close.
  function automatic logic [NIRQ-1:0] close_intr(input logic req,
                                                 input logic eop_close);
    logic [NIRQ-1:0] v;
    v = '0;
    if (req) v[1:0] = 2'b11;
    if (eop_close) v[3] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [1:0]       lane_i,
  input  logic [7:0]       byte_i,
  input  logic             clear_i,
  output logic [31:0]      word_o,
  output logic [LANES-1:0] be_o
);

  logic [31:0]      word_q;
  logic [LANES-1:0] be_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[l*8 +: 8] <= '0;
        be_q[l]          <= 1'b0;
      end else if (push_i && lane_i == l[1:0]) begin
        word_q[l*8 +: 8] <= byte_i;
        be_q[l]          <= 1'b1;
      end else if (clear_i) begin
        be_q[l]          <= 1'b0;
      end
    end
  end

  assign word_o = word_q;
  assign be_o   = be_q;

endmodule

// File: rtl/rxdma_irq.sv
module rxdma_irq
  import rxdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_i,
  input  logic [NIRQ-1:0] ack_i,
  input  logic [NIRQ-1:0] mask_i,
  output logic [NIRQ-1:0] raw_o,
  output logic            irq_o
);

  logic [NIRQ-1:0] raw_q, raw_d, mask_q;
  logic            irq_q;

  assign raw_d = (raw_q & ~ack_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_i;
      if (raw_d != raw_q || mask_i != mask_q)
        irq_q <= |(raw_d & mask_i);
    end
  end

  assign raw_o = raw_q;
  assign irq_o = irq_q;

  // R7: an acknowledged bit that is not set again is gone next cycle.
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i[0] && !set_i[0]) |=> !raw_q[0]);

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   desc_ptr_i,
  input  logic [AW-1:0]   ctx_ptr_i,
  input  logic            s_valid_i,
  input  logic [7:0]      s_data_i,
  input  logic            s_eop_i,
  output logic            s_ready_o,
  output logic            mem_en_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  output logic [3:0]      mem_be_o,
  input  logic [31:0]     mem_rdata_i,
  input  logic [3:0]      intr_mask_i,
  input  logic [3:0]      intr_ack_i,
  output logic [3:0]      raw_intr_o,
  output logic            irq_o,
  output logic            eol_o,
  output logic [AW-1:0]   saved_buf_o
);

  localparam logic [AW-1:0] OFF_FLAGS = AW'(8);
  localparam logic [AW-1:0] OFF_END   = AW'(12);
  localparam logic [AW-1:0] OFF_CTXW  = AW'(4);

  rx_state_e       st_q;
  logic [1:0]      idx_q;
  logic [AW-1:0]   desc_q, ctx_q, next_q, ptr_q, base_q, end_q, waddr_q;
  logic [31:0]     flags_q;
  logic            eop_seen_q, eol_q;

  logic            accept, flush, full_next;
  logic [31:0]     pk_word;
  logic [3:0]      pk_be;
  logic [NIRQ-1:0] set_v;

  assign s_ready_o = (st_q == ST_RUN) && (ptr_q != end_q);
  assign accept    = s_valid_i && s_ready_o;
  assign full_next = (ptr_q + AW'(1)) == end_q;
  assign flush     = accept && must_flush(ptr_q[1:0], full_next, s_eop_i);
  assign set_v     = (st_q == ST_WFLG) ? close_intr(flags_q[FLAG_INTR], eop_seen_q) : '0;

  rxdma_packer u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (accept),
    .lane_i  (ptr_q[1:0]),
    .byte_i  (s_data_i),
    .clear_i (st_q == ST_WRW),
    .word_o  (pk_word),
    .be_o    (pk_be)
  );

  rxdma_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .ack_i  (intr_ack_i),
    .mask_i (intr_mask_i),
    .raw_o  (raw_intr_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      desc_q     <= '0;
      ctx_q      <= '0;
      next_q     <= '0;
      ptr_q      <= '0;
      base_q     <= '0;
      end_q      <= '0;
      waddr_q    <= '0;
      flags_q    <= '0;
      eop_seen_q <= 1'b0;
      eol_q      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_HALT: if (start_i) begin
          desc_q <= desc_ptr_i;
          ctx_q  <= ctx_ptr_i;
          idx_q  <= '0;
          eol_q  <= 1'b0;
          st_q   <= ST_FREQ;
        end
        ST_FREQ: st_q <= ST_FCAP;
        ST_FCAP: begin
          idx_q <= idx_q + 2'd1;
          st_q  <= ST_FREQ;
          case (idx_q)
            2'd0: next_q <= mem_rdata_i[AW-1:0];
            2'd1: begin
              ptr_q  <= mem_rdata_i[AW-1:0];
              base_q <= mem_rdata_i[AW-1:0];
            end
            2'd2: flags_q <= mem_rdata_i;
            default: begin
              end_q      <= mem_rdata_i[AW-1:0];
              eop_seen_q <= 1'b0;
              st_q       <= ST_RUN;
            end
          endcase
        end
        ST_RUN: begin
          if (ptr_q == end_q) begin
            st_q <= ST_WEND;
          end else if (accept) begin
            ptr_q   <= ptr_q + AW'(1);
            waddr_q <= {ptr_q[AW-1:2], 2'b00};
            if (s_eop_i) eop_seen_q <= 1'b1;
            if (flush) st_q <= ST_WRW;
          end
        end
        ST_WRW:  st_q <= (ptr_q == end_q || eop_seen_q) ? ST_WEND : ST_RUN;
        ST_WEND: st_q <= ST_WFLG;
        ST_WFLG: begin
          if (flags_q[FLAG_EOL]) begin
            st_q <= ST_CREQ;
          end else begin
            desc_q <= next_q;
            idx_q  <= '0;
            st_q   <= ST_FREQ;
          end
        end
        ST_CREQ: st_q <= ST_CCAP;
        ST_CCAP: begin
          eol_q <= 1'b1;
          st_q  <= ST_HALT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_be_o    = '0;
    unique case (st_q)
      ST_FREQ: begin
        mem_en_o   = 1'b1;
        mem_addr_o = desc_q + AW'({idx_q, 2'b00});
      end
      ST_WRW: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = waddr_q;
        mem_wdata_o = pk_word;
        mem_be_o    = pk_be;
      end
      ST_WEND: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + OFF_END;
        mem_wdata_o = 32'(ptr_q);
        mem_be_o    = 4'hF;
      end
      ST_WFLG: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + OFF_FLAGS;
        mem_wdata_o = close_flags(flags_q, eop_seen_q);
        mem_be_o    = 4'hF;
      end
      ST_CREQ: begin
        mem_en_o   = 1'b1;
        mem_addr_o = ctx_q + OFF_CTXW;
      end
      ST_CCAP: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_q + OFF_CTXW;
        mem_wdata_o = mem_rdata_i | (32'd1 << CTX_DIS);
        mem_be_o    = 4'hF;
      end
      default: ;
    endcase
  end

  assign eol_o       = eol_q;
  assign saved_buf_o = ptr_q;

  assert_no_ready_at_eol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |-> !s_ready_o);

  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o) |=> (ptr_q == $past(ptr_q) + AW'(1)));

  assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> ((ptr_q - base_q) <= (end_q - base_q)));

  assert_data_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRW) |-> (mem_we_o && mem_be_o != 4'h0));

  assert_ctx_before_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eol_o) |-> $past(mem_we_o && mem_wdata_o[CTX_DIS]));

endmodule

// File: tb/rxdma_engine_tb_top.sv
module rxdma_engine_tb_top;

  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] desc_ptr_i = '0, ctx_ptr_i = '0;
  logic          s_valid_i = 1'b0, s_eop_i = 1'b0;
  logic [7:0]    s_data_i = '0;
  logic          s_ready_o;
  logic          mem_en_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i;
  logic [3:0]    mem_be_o;
  logic [3:0]    intr_mask_i = '0, intr_ack_i = '0, raw_intr_o;
  logic          irq_o, eol_o;
  logic [AW-1:0] saved_buf_o;

  rxdma_engine #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
    .ctx_ptr_i(ctx_ptr_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_eop_i(s_eop_i), .s_ready_o(s_ready_o), .mem_en_o(mem_en_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_be_o(mem_be_o), .mem_rdata_i(mem_rdata_i), .intr_mask_i(intr_mask_i),
    .intr_ack_i(intr_ack_i), .raw_intr_o(raw_intr_o), .irq_o(irq_o),
    .eol_o(eol_o), .saved_buf_o(saved_buf_o)
  );

  // Bench memory: 256 words, byte addresses 0x000..0x3FF.
  logic [31:0] bm [256];
  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) bm[mem_addr_o[9:2]][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
      end else begin
        mem_rdata_i <= bm[mem_addr_o[9:2]];
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int rd_byte(input int a);
    return int'(bm[a[9:2]][a[1:0]*8 +: 8]);
  endfunction

  function automatic int pat(input int v, input int k);
    return (v * 16 + k + 8'h30) & 8'hFF;
  endfunction

  task automatic put_desc(input int at, input int nxt, input int bs, input int flg, input int cap);
    bm[at[9:2]]     = 32'(nxt);
    bm[at[9:2] + 1] = 32'(bs);
    bm[at[9:2] + 2] = 32'(flg);
    bm[at[9:2] + 3] = 32'(bs + cap);
  endtask

  task automatic kick(input int d);
    @(negedge clk);
    desc_ptr_i = AW'(d);
    ctx_ptr_i  = AW'(16'h40);
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  task automatic send(input int b, input bit e);
    @(negedge clk);
    s_valid_i = 1'b1; s_data_i = 8'(b); s_eop_i = e;
    while (!s_ready_o) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_valid_i = 1'b0; s_eop_i = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!eol_o && n < 300) begin @(negedge clk); n++; end
    chk(eol_o == 1'b1, req, "stop flag", int'(eol_o), 1);
  endtask

  task automatic ack_all();
    @(negedge clk); intr_ack_i = 4'hF;
    @(negedge clk); intr_ack_i = 4'h0;
    @(negedge clk);
  endtask

  // Vector table: buffer start, capacity, packet length, eop, interrupt request.
  localparam int NV = 6;
  localparam int V_BUF  [NV] = '{32'h100, 32'h121, 32'h142, 32'h163, 32'h180, 32'h1A1};
  localparam int V_CAP  [NV] = '{8, 6, 12, 1, 0, 9};
  localparam int V_PLEN [NV] = '{8, 10, 5, 1, 0, 3};
  localparam int V_EOP  [NV] = '{1, 1, 1, 0, 0, 1};
  localparam int V_INTR [NV] = '{1, 0, 1, 1, 0, 0};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) bm[i] = 32'hEEEE_EEEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(s_ready_o == 1'b0, "R1", "ready", int'(s_ready_o), 0);
    chk(eol_o == 1'b0, "R1", "stop flag", int'(eol_o), 0);
    chk(irq_o == 1'b0, "R1", "irq", int'(irq_o), 0);
    chk(raw_intr_o == 4'h0, "R1", "raw", int'(raw_intr_o), 0);

    for (int v = 0; v < NV; v++) begin
      int bs, cap, n, fill, flg, bad, expraw, expflg;
      bit eopc;
      bs = V_BUF[v]; cap = V_CAP[v];
      for (int i = 64; i < 128; i++) bm[i] = 32'hEEEE_EEEE;
      flg = 1 | (V_INTR[v] << 4) | (1 << 20);
      put_desc(0, 0, bs, flg, cap);
      bm[17] = 32'h0000_0003;
      kick(0);
      n = (V_PLEN[v] < cap) ? V_PLEN[v] : cap;
      eopc = (V_EOP[v] != 0) && (V_PLEN[v] <= cap) && (V_PLEN[v] > 0);
      for (int k = 0; k < n; k++)
        send(pat(v, k), eopc && (k == n - 1));
      fill = n;
      wait_halt("R8");
      if (V_PLEN[v] > cap) begin
        // R3: excess byte is refused
        @(negedge clk); s_valid_i = 1'b1; s_data_i = 8'h5A;
        repeat (4) @(negedge clk);
        chk(s_ready_o == 1'b0, "R3", "ready after full", int'(s_ready_o), 0);
        s_valid_i = 1'b0;
        chk(rd_byte(bs + cap) == 8'hEE, "R3", "byte past end", rd_byte(bs + cap), 8'hEE);
      end
      bad = 0;
      for (int a = bs - 1; a <= bs + cap; a++) begin
        int e;
        e = (a >= bs && a < bs + fill) ? pat(v, a - bs) : 8'hEE;
        if (rd_byte(a) != e) bad++;
      end
      chk(bad == 0, "R2", "mismatching buffer bytes", bad, 0);
      chk(bm[3] == 32'(bs + fill), "R4", "end pointer word", int'(bm[3]), bs + fill);
      expflg = flg | (eopc ? (1 << 11) : 0);
      chk(bm[2] == 32'(expflg), "R5", "flags write-back", int'(bm[2]), expflg);
      expraw = (V_INTR[v] != 0 ? 3 : 0) | (eopc ? 8 : 0);
      chk(raw_intr_o == 4'(expraw), "R6", "raw interrupts", int'(raw_intr_o), expraw);
      chk(bm[17] == 32'h0000_8003, "R8", "context word", int'(bm[17]), 32'h8003);
      chk(saved_buf_o == AW'(bs + fill), "R10", "fill pointer", int'(saved_buf_o), bs + fill);
      ack_all();
      chk(raw_intr_o == 4'h0, "R7", "raw after ack", int'(raw_intr_o), 0);
    end

    // R9: chained descriptors, short packet in the first one
    for (int i = 128; i < 160; i++) bm[i] = 32'hEEEE_EEEE;
    put_desc(0, 16'h10, 16'h200, (1 << 4), 16);
    put_desc(16'h10, 0, 16'h240, 1 | (1 << 4), 4);
    bm[17] = 32'h0000_0000;
    kick(0);
    send(8'hA0, 1'b0); send(8'hA1, 1'b0); send(8'hA2, 1'b1);
    begin
      int n = 0;
      while (!s_ready_o && n < 100) begin @(negedge clk); n++; end
    end
    chk(saved_buf_o == AW'(16'h240), "R9", "second buffer start", int'(saved_buf_o), 16'h240);
    chk(bm[3] == 32'h203, "R4", "truncated end pointer", int'(bm[3]), 32'h203);
    chk(bm[2] == 32'h810, "R5", "first flags", int'(bm[2]), 32'h810);
    chk(eol_o == 1'b0, "R9", "still running", int'(eol_o), 0);
    for (int k = 0; k < 4; k++) send(8'hB0 + k, 1'b0);
    wait_halt("R8");
    chk(bm[16'h240 >> 2] == 32'hB3B2_B1B0, "R2", "second buffer word", int'(bm[16'h240 >> 2]), 32'hB3B2B1B0);
    chk(bm[16'h200 >> 2] == 32'hEEA2_A1A0, "R2", "partial word", int'(bm[16'h200 >> 2]), 32'hEEA2A1A0);
    chk(bm[7] == 32'h244, "R4", "second end pointer", int'(bm[7]), 32'h244);
    chk(bm[6] == 32'h11, "R5", "second flags", int'(bm[6]), 32'h11);
    chk(bm[17] == 32'h8000, "R8", "context disable", int'(bm[17]), 32'h8000);
    chk(raw_intr_o == 4'hB, "R6", "raw after chain", int'(raw_intr_o), 4'hB);

    // R7: masking and acknowledge
    @(negedge clk); intr_mask_i = 4'h8;
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b1, "R7", "irq with bit3 mask", int'(irq_o), 1);
    intr_ack_i = 4'h8; @(negedge clk); intr_ack_i = 4'h0;
    @(negedge clk);
    chk(raw_intr_o == 4'h3, "R7", "raw after bit3 ack", int'(raw_intr_o), 3);
    chk(irq_o == 1'b0, "R7", "irq after ack", int'(irq_o), 0);
    intr_mask_i = 4'h1;
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b1, "R7", "irq with bit0 mask", int'(irq_o), 1);
    ack_all();
    @(negedge clk);
    chk(irq_o == 1'b0, "R7", "irq after full ack", int'(irq_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule